// File: doc/BRIEF.md
# Nibble-stream predictive sample decoder

This block turns a stream of packed 4-bit samples in a byte-wide memory into 16-bit output samples. Software sets up the block through a small register bus. It programs a start, an end and a current position in nibble units, a gain and a bank of coefficient pairs. It then selects one pair and loads two history samples. After that, every bus read of the sample register returns one decoded value and moves the position forward by one nibble. When the position reaches the end, it jumps back to the start.

Each output is computed as follows. The signed nibble is multiplied by the gain. The two newest previous outputs are multiplied by the selected coefficient pair. The three products are summed in a 32-bit accumulator, shifted right arithmetically by 11 and clamped to 16 bits. So 0x0800 means unity, 0x0400 means one half and 0x0200 means one quarter. The clamped value is both returned on the bus and pushed into the history.

The memory port has no handshake. The block keeps its byte address equal to the byte of the position that will hold after the coming clock edge. Because the memory has one cycle of latency, the byte for the current position is always ready, so sample reads can be issued back to back.

Top module: `pcm_stream_accel`

## Requirements
- R1: Registers are written with `bus_wr` and read with `bus_rd`. Every register reads back the last value written to it. The map is: 0x00 format, 0x01 gain, 0x02 pair select, 0x03 newer history, 0x04 older history, 0x05 sample output, 0x08/0x09 start high/low, 0x0A/0x0B end high/low, 0x0C/0x0D current high/low, 0x10+2k coefficient one of pair k, 0x11+2k coefficient two of pair k. A high half holds address bits 31..16 and a low half holds bits 15..0.
- R2: `mem_addr` equals the current nibble address shifted right by one. An even address decodes bits 7..4 of the byte and an odd address decodes bits 3..0. The nibble is a two's-complement value from -8 to 7.
- R3: A read of 0x05 returns on `bus_rdata` at the clock edge after the read is taken. The value is clamp16(((nib*gain + c1*h1 + c2*h2) mod 2^32 as signed) >>> 11), where c1 and c2 are the selected pair, h1 is the newer history and h2 is the older history.
- R4: After a sample read, the older history takes the previous newer history and the newer history takes the returned sample. Both are readable and writable.
- R5: The pair-select register keeps its low 3 bits, and these bits choose which coefficient pair the filter uses.
- R6: A write to the format register clears the pair select and both history registers to zero.
- R7: A sample read advances the current address by one. If the current address is already greater than or equal to the end address (unsigned), the current address becomes the start address instead.
- R8: After reset, every register and `bus_rdata` read as zero. `bus_rdata` changes only at a taken read.
- R9: A result above 32767 returns 32767, and a result below -32768 returns -32768.
- R10: A read of any register other than 0x05 leaves the current address and the history unchanged. When `bus_wr` and `bus_rd` are high together, the write is done and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| mem_addr | output | MEM_AW | Byte address to the sample memory |
| mem_rdata | input | 8 | Byte from the memory, one cycle after its address |

## Verification
Any read result appears on `bus_rdata` at the first rising edge after the strobe. The bench therefore samples it at the following falling edge, including during back-to-back sample bursts where each falling edge both holds the strobe and collects the previous value. The `mem_addr` output is combinational from the next-position logic, so after a write of the current address it is checked at the falling edge after that write. History and position effects are checked by reading those registers back through the bus once the burst is over. The expected values come from a bench model of the filter with 32-bit wrapping integer arithmetic.

// File: rtl/psa_pkg.sv
package psa_pkg;
   localparam int BUS_AW    = 6;
   localparam int SMP_W     = 16;
   localparam int COEF_BASE = 16;

   localparam logic [BUS_AW-1:0] RA_FMT    = 6'h00;
   localparam logic [BUS_AW-1:0] RA_GAIN   = 6'h01;
   localparam logic [BUS_AW-1:0] RA_PSEL   = 6'h02;
   localparam logic [BUS_AW-1:0] RA_HIST1  = 6'h03;
   localparam logic [BUS_AW-1:0] RA_HIST2  = 6'h04;
   localparam logic [BUS_AW-1:0] RA_SAMPLE = 6'h05;
   localparam logic [BUS_AW-1:0] RA_BEG_HI = 6'h08;
   localparam logic [BUS_AW-1:0] RA_BEG_LO = 6'h09;
   localparam logic [BUS_AW-1:0] RA_FIN_HI = 6'h0A;
   localparam logic [BUS_AW-1:0] RA_FIN_LO = 6'h0B;
   localparam logic [BUS_AW-1:0] RA_POS_HI = 6'h0C;
   localparam logic [BUS_AW-1:0] RA_POS_LO = 6'h0D;
endpackage

// File: rtl/psa_addr_unit.sv
module psa_addr_unit
   import psa_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int MEM_AW = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [BUS_AW-1:0] waddr_i,
   input  logic [15:0]       wdata_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] beg_o,
   output logic [ADDR_W-1:0] fin_o,
   output logic [ADDR_W-1:0] pos_o,
   output logic [MEM_AW-1:0] mem_addr_o
);
   localparam int HI_W = ADDR_W - 16;

   logic [ADDR_W-1:0] beg_q, fin_q, pos_q, pos_d;

   function automatic logic [ADDR_W-1:0] put_half(input logic [ADDR_W-1:0] old,
                                                  input logic hi,
                                                  input logic [15:0] d);
      logic [ADDR_W-1:0] r;
      r = old;
      if (hi) r[ADDR_W-1:16] = d[HI_W-1:0];
      else    r[15:0]        = d;
      return r;
   endfunction

   always_comb begin
      pos_d = pos_q;
      if (adv_i) begin
         if (pos_q >= fin_q) pos_d = beg_q;
         else                pos_d = pos_q + ADDR_W'(1);
      end else if (wr_i && waddr_i == RA_POS_HI) begin
         pos_d = put_half(pos_q, 1'b1, wdata_i);
      end else if (wr_i && waddr_i == RA_POS_LO) begin
         pos_d = put_half(pos_q, 1'b0, wdata_i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beg_q <= '0;
         fin_q <= '0;
         pos_q <= '0;
      end else begin
         pos_q <= pos_d;
         if (wr_i && !adv_i) begin
            if (waddr_i == RA_BEG_HI) beg_q <= put_half(beg_q, 1'b1, wdata_i);
            if (waddr_i == RA_BEG_LO) beg_q <= put_half(beg_q, 1'b0, wdata_i);
            if (waddr_i == RA_FIN_HI) fin_q <= put_half(fin_q, 1'b1, wdata_i);
            if (waddr_i == RA_FIN_LO) fin_q <= put_half(fin_q, 1'b0, wdata_i);
         end
      end
   end

   assign mem_addr_o = pos_d[MEM_AW:1];
   assign beg_o      = beg_q;
   assign fin_o      = fin_q;
   assign pos_o      = pos_q;

   p_wrap_to_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && pos_q >= fin_q) |=> pos_q == $past(beg_q));
   p_step_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && pos_q < fin_q) |=> pos_q == $past(pos_q) + ADDR_W'(1));
   p_mem_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> pos_q[MEM_AW:1] == $past(mem_addr_o));
endmodule

// File: rtl/psa_coef_bank.sv
module psa_coef_bank
   import psa_pkg::*;
#(
   parameter int NUM_PAIRS = 8,
   parameter int COEF_W    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_i,
   input  logic [BUS_AW-1:0]        waddr_i,
   input  logic [15:0]              wdata_i,
   input  logic                     fmt_wr_i,
   input  logic [BUS_AW-1:0]        raddr_i,
   output logic [15:0]              rdata_o,
   output logic [$clog2(NUM_PAIRS)-1:0] psel_o,
   output logic signed [COEF_W-1:0] c1_o,
   output logic signed [COEF_W-1:0] c2_o
);
   localparam int PSEL_W = $clog2(NUM_PAIRS);

   logic signed [COEF_W-1:0] c1_q [NUM_PAIRS];
   logic signed [COEF_W-1:0] c2_q [NUM_PAIRS];
   logic [PSEL_W-1:0]        psel_q;

   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      localparam logic [BUS_AW-1:0] A1 = BUS_AW'(COEF_BASE + 2*k);
      localparam logic [BUS_AW-1:0] A2 = BUS_AW'(COEF_BASE + 2*k + 1);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            c1_q[k] <= '0;
            c2_q[k] <= '0;
         end else if (wr_i) begin
            if (waddr_i == A1) c1_q[k] <= wdata_i[COEF_W-1:0];
            if (waddr_i == A2) c2_q[k] <= wdata_i[COEF_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                              psel_q <= '0;
      else if (fmt_wr_i)                       psel_q <= '0;
      else if (wr_i && waddr_i == RA_PSEL)     psel_q <= wdata_i[PSEL_W-1:0];
   end

   always_comb begin
      rdata_o = '0;
      for (int k = 0; k < NUM_PAIRS; k++) begin
         if (raddr_i == BUS_AW'(COEF_BASE + 2*k))     rdata_o = 16'(c1_q[k]);
         if (raddr_i == BUS_AW'(COEF_BASE + 2*k + 1)) rdata_o = 16'(c2_q[k]);
      end
   end

   assign psel_o = psel_q;
   assign c1_o   = c1_q[psel_q];
   assign c2_o   = c2_q[psel_q];

   p_sel_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_wr_i |=> psel_q == '0);
   p_sel_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !fmt_wr_i && waddr_i == RA_PSEL) |=> psel_q == $past(wdata_i[PSEL_W-1:0]));
endmodule

// File: rtl/psa_predictor.sv
module psa_predictor
   import psa_pkg::*;
#(
   parameter int ACC_W    = 32,
   parameter int FRAC     = 11,
   parameter bit SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step_i,
   input  logic [3:0]              nib_i,
   input  logic signed [SMP_W-1:0] gain_i,
   input  logic signed [SMP_W-1:0] c1_i,
   input  logic signed [SMP_W-1:0] c2_i,
   input  logic                    clr_i,
   input  logic                    h1_we_i,
   input  logic                    h2_we_i,
   input  logic [15:0]             wdata_i,
   output logic signed [SMP_W-1:0] h1_o,
   output logic signed [SMP_W-1:0] h2_o,
   output logic signed [SMP_W-1:0] result_o
);
   localparam int PROD_W = 2 * SMP_W;
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'(32767);
   localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

   logic signed [SMP_W-1:0]  nib_s;
   logic signed [PROD_W-1:0] p0, p1, p2;
   logic signed [ACC_W-1:0]  acc, shifted;
   logic signed [SMP_W-1:0]  h1_q, h2_q;

   assign nib_s   = {{(SMP_W-4){nib_i[3]}}, nib_i};
   assign p0      = nib_s * gain_i;
   assign p1      = c1_i * h1_q;
   assign p2      = c2_i * h2_q;
   assign acc     = ACC_W'(p0) + ACC_W'(p1) + ACC_W'(p2);
   assign shifted = acc >>> FRAC;

   if (SATURATE) begin : g_clamp
      always_comb begin
         if (shifted > MAXV)      result_o = 16'sh7fff;
         else if (shifted < MINV) result_o = 16'sh8000;
         else                     result_o = shifted[SMP_W-1:0];
      end
   end else begin : g_wrap
      assign result_o = shifted[SMP_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         h1_q <= '0;
         h2_q <= '0;
      end else if (step_i) begin
         h1_q <= result_o;
         h2_q <= h1_q;
      end else begin
         if (h1_we_i) h1_q <= wdata_i;
         if (h2_we_i) h2_q <= wdata_i;
      end
   end

   assign h1_o = h1_q;
   assign h2_o = h2_q;

   p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clr_i) |=> (h2_q == $past(h1_q)) && (h1_q == $past(result_o)));
   p_hist_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (h1_q == '0) && (h2_q == '0));
endmodule

// File: rtl/pcm_stream_accel.sv
module pcm_stream_accel
   import psa_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MEM_AW    = 10,
   parameter int NUM_PAIRS = 8,
   parameter int ACC_W     = 32,
   parameter bit SATURATE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [5:0]        bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic [7:0]        mem_rdata
);
   localparam int FRAC   = 11;
   localparam int PSEL_W = $clog2(NUM_PAIRS);

   if (ADDR_W < 17 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 17..32");
   end
   if (MEM_AW < 1 || MEM_AW >= ADDR_W) begin : g_bad_mem
      $error("MEM_AW must be below ADDR_W");
   end
   if (NUM_PAIRS < 2 || NUM_PAIRS > 8 || (1 << PSEL_W) != NUM_PAIRS) begin : g_bad_pairs
      $error("NUM_PAIRS must be 2, 4 or 8");
   end
   if (ACC_W < 32) begin : g_bad_acc
      $error("ACC_W must be at least 32");
   end

   logic rd_go, smp_go, fmt_wr;
   logic [15:0] fmt_q;
   logic signed [SMP_W-1:0] gain_q;
   logic [ADDR_W-1:0] beg, fin, pos;
   logic [15:0] coef_rdata;
   logic [PSEL_W-1:0] psel;
   logic signed [SMP_W-1:0] c1, c2, h1, h2, result;
   logic [3:0] nib;

   assign rd_go  = bus_rd && !bus_wr;
   assign smp_go = rd_go && bus_addr == RA_SAMPLE;
   assign fmt_wr = bus_wr && bus_addr == RA_FMT;
   assign nib    = pos[0] ? mem_rdata[3:0] : mem_rdata[7:4];

   psa_addr_unit #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .waddr_i(bus_addr),
      .wdata_i(bus_wdata), .adv_i(smp_go), .beg_o(beg), .fin_o(fin),
      .pos_o(pos), .mem_addr_o(mem_addr)
   );

   psa_coef_bank #(.NUM_PAIRS(NUM_PAIRS), .COEF_W(SMP_W)) u_coef (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .waddr_i(bus_addr),
      .wdata_i(bus_wdata), .fmt_wr_i(fmt_wr), .raddr_i(bus_addr),
      .rdata_o(coef_rdata), .psel_o(psel), .c1_o(c1), .c2_o(c2)
   );

   psa_predictor #(.ACC_W(ACC_W), .FRAC(FRAC), .SATURATE(SATURATE)) u_pred (
      .clk(clk), .rst_n(rst_n), .step_i(smp_go), .nib_i(nib),
      .gain_i(gain_q), .c1_i(c1), .c2_i(c2), .clr_i(fmt_wr),
      .h1_we_i(bus_wr && bus_addr == RA_HIST1),
      .h2_we_i(bus_wr && bus_addr == RA_HIST2),
      .wdata_i(bus_wdata), .h1_o(h1), .h2_o(h2), .result_o(result)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q  <= '0;
         gain_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == RA_FMT)  fmt_q  <= bus_wdata;
         if (bus_addr == RA_GAIN) gain_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_go) begin
         case (bus_addr)
            RA_FMT:    bus_rdata <= fmt_q;
            RA_GAIN:   bus_rdata <= gain_q;
            RA_PSEL:   bus_rdata <= 16'(psel);
            RA_HIST1:  bus_rdata <= h1;
            RA_HIST2:  bus_rdata <= h2;
            RA_SAMPLE: bus_rdata <= result;
            RA_BEG_HI: bus_rdata <= 16'(beg >> 16);
            RA_BEG_LO: bus_rdata <= beg[15:0];
            RA_FIN_HI: bus_rdata <= 16'(fin >> 16);
            RA_FIN_LO: bus_rdata <= fin[15:0];
            RA_POS_HI: bus_rdata <= 16'(pos >> 16);
            RA_POS_LO: bus_rdata <= pos[15:0];
            default:   bus_rdata <= coef_rdata;
         endcase
      end
   end

   p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> $stable(bus_rdata));
   p_read_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && bus_addr != RA_SAMPLE) |=> $stable(pos) && $stable(h1) && $stable(h2));
   p_fmt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_wr |=> (psel == '0) && (h1 == '0) && (h2 == '0));
   p_sample_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      smp_go |=> bus_rdata == $past(result) && h1 == $signed(bus_rdata));
endmodule

// File: tb/pcm_stream_accel_bench.sv
module pcm_stream_accel_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic [9:0] mem_addr;
   logic [7:0] mem_rdata;
   logic [7:0] mem [1024];

   int checks = 0, failures = 0;
   bit finished = 0;

   int unsigned m_beg, m_fin, m_pos;
   logic signed [15:0] m_gain, m_h1, m_h2;
   logic [2:0] m_psel;
   logic signed [15:0] m_c1 [8];
   logic signed [15:0] m_c2 [8];

   always #4 clk = ~clk;

   always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

   pcm_stream_accel u_pcm_stream_accel (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   function automatic logic signed [15:0] model_sample();
      int n, acc;
      logic [7:0] b;
      b = mem[(m_pos >> 1) & 32'd1023];
      n = m_pos[0] ? int'(b[3:0]) : int'(b[7:4]);
      if (n > 7) n -= 16;
      acc = n * int'(m_gain) + int'(m_c1[m_psel]) * int'(m_h1) + int'(m_c2[m_psel]) * int'(m_h2);
      acc = acc >>> 11;
      if (acc > 32767) acc = 32767;
      if (acc < -32768) acc = -32768;
      return 16'(acc);
   endfunction

   function automatic logic signed [15:0] model_step();
      logic signed [15:0] r;
      r = model_sample();
      m_h2 = m_h1;
      m_h1 = r;
      if (m_pos >= m_fin) m_pos = m_beg;
      else m_pos = m_pos + 1;
      return r;
   endfunction

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         6'h00: begin m_psel = 0; m_h1 = 0; m_h2 = 0; end
         6'h01: m_gain = d;
         6'h02: m_psel = d[2:0];
         6'h03: m_h1 = d;
         6'h04: m_h2 = d;
         6'h08: m_beg = {d, m_beg[15:0]};
         6'h09: m_beg = {m_beg[31:16], d};
         6'h0A: m_fin = {d, m_fin[15:0]};
         6'h0B: m_fin = {m_fin[31:16], d};
         6'h0C: m_pos = {d, m_pos[15:0]};
         6'h0D: m_pos = {m_pos[31:16], d};
         default: if (a >= 6'h10 && a < 6'h20) begin
            if (a[0]) m_c2[a[3:1]] = d; else m_c1[a[3:1]] = d;
         end
      endcase
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic burst(input int n, input string req);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 6'h05;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == n - 1) bus_rd = 1'b0;
         chk(req, bus_rdata, model_step());
      end
   endtask

   task automatic set_pos(input int unsigned b, input int unsigned f, input int unsigned p);
      wr(6'h08, b[31:16]); wr(6'h09, b[15:0]);
      wr(6'h0A, f[31:16]); wr(6'h0B, f[15:0]);
      wr(6'h0C, p[31:16]); wr(6'h0D, p[15:0]);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin : main
      logic [15:0] d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
      m_beg = 0; m_fin = 0; m_pos = 0; m_gain = 0; m_h1 = 0; m_h2 = 0; m_psel = 0;
      for (int k = 0; k < 8; k++) begin m_c1[k] = 0; m_c2[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: reset state
      chk("R8 rdata", bus_rdata, 16'h0);
      rd(6'h00, d); chk("R8 fmt", d, 16'h0);
      rd(6'h03, d); chk("R8 hist1", d, 16'h0);
      rd(6'h0D, d); chk("R8 pos", d, 16'h0);
      rd(6'h11, d); chk("R8 coef", d, 16'h0);

      // R1: readback
      wr(6'h01, 16'h0800); rd(6'h01, d); chk("R1 gain", d, 16'h0800);
      wr(6'h1D, 16'hBEEF); rd(6'h1D, d); chk("R1 coef", d, 16'hBEEF);
      set_pos(32'h1234_0010, 32'h5678_0020, 32'h0001_0004);
      rd(6'h08, d); chk("R1 beg hi", d, 16'h1234);
      rd(6'h0B, d); chk("R1 fin lo", d, 16'h0020);
      rd(6'h0C, d); chk("R1 pos hi", d, 16'h0001);
      chk("R2 mem_addr", {6'h0, mem_addr}, 16'h0002);

      // R6: format write clears select and history
      wr(6'h02, 16'h0005); wr(6'h03, 16'h1111); wr(6'h04, 16'h2222);
      rd(6'h02, d); chk("R5 psel", d, 16'h0005);
      wr(6'h00, 16'h0008);
      rd(6'h00, d); chk("R1 fmt", d, 16'h0008);
      rd(6'h02, d); chk("R6 psel", d, 16'h0);
      rd(6'h03, d); chk("R6 hist1", d, 16'h0);
      rd(6'h04, d); chk("R6 hist2", d, 16'h0);

      // R3 R2 R7: unity gain, halves and quarters, nibble order
      mem[8] = 8'h3C; mem[9] = 8'h71;
      set_pos(16, 19, 16);
      wr(6'h10, 16'h0400); wr(6'h11, 16'h0200);
      burst(6, "R3 R2 R7 pcm order");
      rd(6'h0D, d); chk("R7 wrap pos", d, m_pos[15:0]);
      rd(6'h03, d); chk("R4 hist1", d, m_h1);
      rd(6'h04, d); chk("R4 hist2", d, m_h2);

      // R10: other reads and simultaneous strobes
      rd(6'h0C, d);
      rd(6'h0D, d); chk("R10 pos kept", d, m_pos[15:0]);
      @(negedge clk);
      bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 6'h05; bus_wdata = 16'h0;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      chk("R10 read dropped", bus_rdata, m_pos[15:0]);
      rd(6'h03, d); chk("R10 hist kept", d, m_h1);

      // R9: clamping both ways
      mem[100] = 8'h77;
      set_pos(200, 200, 200);
      wr(6'h01, 16'h7fff); wr(6'h00, 16'h0008);
      wr(6'h10, 16'h7fff); wr(6'h11, 16'h0000);
      wr(6'h03, 16'h7fff);
      rd(6'h05, d); chk("R9 high clamp", d, 16'h7fff); void'(model_step());
      wr(6'h03, 16'h8000);
      rd(6'h05, d); chk("R9 low clamp", d, 16'h8000); void'(model_step());
      rd(6'h0D, d); chk("R7 end equals start", d, 16'd200);

      // R3 R4 R5 R7: random programs
      for (int t = 0; t < 12; t++) begin
         int unsigned b, len;
         b = $urandom_range(0, 1500);
         len = $urandom_range(0, 30);
         set_pos(b, b + len, b + $urandom_range(0, len));
         wr(6'h01, (t % 3 == 0) ? 16'(16'h7fff - $urandom_range(0, 3)) : 16'($urandom_range(0, 16'h1000)));
         for (int k = 0; k < 8; k++) begin
            wr(6'(16 + 2*k), 16'($signed($urandom_range(0, 16'h1000)) - 32'sh800));
            wr(6'(17 + 2*k), 16'($signed($urandom_range(0, 16'h0800)) - 32'sh400));
         end
         wr(6'h00, 16'h0008);
         wr(6'h02, 16'($urandom_range(0, 15)));
         wr(6'h03, 16'($urandom));
         wr(6'h04, 16'($urandom));
         burst($urandom_range(4, 40), "R3 R5 R7 random burst");
         rd(6'h0D, d); chk("R7 pos after burst", d, m_pos[15:0]);
         rd(6'h04, d); chk("R4 hist2 after burst", d, m_h2);
         chk("R2 mem_addr follows", {6'h0, mem_addr}, 16'((m_pos >> 1) & 32'd1023));
      end
      summary();
   end
endmodule